// File: doc/BRIEF.md
# Endian-Aware Load/Store Lane Aligner

This block sits between a processor's load/store unit and a 64-bit memory data path. A load request carries the accessed bytes right-justified on the register side; the block places them in the lanes of the memory element that the physical address, the access length and the memory byte order call for. A store request goes the other way. The element comes in on the memory side and the block returns the selected bytes right-justified, together with a byte-enable vector for the memory write.

Before it computes any lane position, the block can apply a reverse-endian swizzle to the low address bits. It flags any access that would run past the aligned element boundary. An instruction-fetch variant also checks fetch alignment, and after the lane move it selects the fetched bytes with a shift that depends on the processor byte order. All results come out of one register stage with a valid strobe.

Top module: `mem_lane_align`

## Requirements
- R1: `req_len` holds the byte count minus one (0 = one byte, 3 = four bytes, 7 = eight bytes; every value 0..7 is legal). Let p be the byte offset after the R6 swizzle. When p + `req_len` > 7, `rsp_cross_err` is 1, and both `rsp_data` and `rsp_be` are 0.
- R2: For a load (`req_op` = 0, or the unused code 3) with little-endian memory (`mem_big_endian` = 0), `rsp_data` is the low `req_len`+1 bytes of `req_data` shifted left by 8·p bits.
- R3: For a load with big-endian memory, the shift is 8·((7 − p) − `req_len`) bits to the left.
- R4: For a store (`req_op` = 1), the block uses the R2/R3 shift amount as a right shift of `req_data`. It keeps only the low `req_len`+1 bytes of the result.
- R5: When `req_len` = 7 (full element), no lane shift is applied in any direction or byte order.
- R6: With `reverse_endian` = 1, the low three bits of `rsp_addr` are the low three bits of `req_addr` XOR (7 XOR `req_len`). With `reverse_endian` = 0 they are equal to the low three address bits. The upper address bits always pass through unchanged.
- R7: For a fetch (`req_op` = 2), `rsp_fetch_fault` is 1 when `req_addr` AND `req_len` is nonzero. A fault forces `rsp_data` and `rsp_be` to 0.
- R8: A fetch first forms the R2/R3 load result. It then shifts that result right by 8·((`req_addr` AND 7) XOR c) bits, where c = 7 XOR `req_len` when `cpu_big_endian` = 1 and c = 0 otherwise.
- R9: For a store, `rsp_be` has exactly `req_len`+1 contiguous bits set, starting at bit (shift amount / 8). For loads and fetches, `rsp_be` is 0.
- R10: Every output is registered. `rsp_valid` is `req_valid` delayed by one clock, and after reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | 0 load, 1 store, 2 fetch, 3 treated as load |
| req_addr | input | 32 | Physical byte address |
| req_len | input | 3 | Byte count minus one |
| req_data | input | 64 | Register-side bytes (load/fetch) or memory element (store) |
| mem_big_endian | input | 1 | Memory byte order is big-endian |
| reverse_endian | input | 1 | Apply the low-address swizzle |
| cpu_big_endian | input | 1 | Processor byte order for fetch selection |
| rsp_valid | output | 1 | Result strobe, one cycle after the request |
| rsp_addr | output | 32 | Swizzled address |
| rsp_data | output | 64 | Aligned data |
| rsp_be | output | 8 | Store byte enables |
| rsp_cross_err | output | 1 | Access crosses the aligned element |
| rsp_fetch_fault | output | 1 | Misaligned fetch |

## Verification
The bench builds the block with its default 8-byte element and 32-bit address. With those values, a full sweep covers every pairing of operation, memory byte order, reverse swizzle, length code and byte offset, and the processor byte order is also swept for fetches. The sweep therefore reaches every crossing case, every odd length and every fetch misalignment, and the bench computes the expected lanes from shift arithmetic.

// File: rtl/lal_pkg.sv
// Package for the lane aligner: operation codes shared by the top and the lane mover.
package lal_pkg;
    typedef enum logic [1:0] {
        LAL_LOAD  = 2'd0,
        LAL_STORE = 2'd1,
        LAL_FETCH = 2'd2,
        LAL_SPARE = 2'd3   // decoded as a load
    } lal_op_e;
endpackage

// File: rtl/lal_addr_swizzle.sv
// Reverse-endian address swizzle.
// The low offset bits are XORed with (mask ^ len) when the swizzle is enabled.
// The upper bits pass through. Assumes ADDR_W > OFFS_W. Purely combinational.
module lal_addr_swizzle #(
    parameter int ADDR_W = 32,
    parameter int OFFS_W = 3
) (
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [OFFS_W-1:0] len_code,
    input  logic              swz_en,
    output logic [ADDR_W-1:0] addr_out
);
    localparam logic [OFFS_W-1:0] OFFS_MASK = '1;

    logic [OFFS_W-1:0] flip;

    // Pick the XOR pattern for the current access length.
    always_comb begin
        flip = swz_en ? (OFFS_MASK ^ len_code) : '0;
    end

    // Rebuild the address with only the low offset bits altered.
    always_comb begin
        addr_out = {addr_in[ADDR_W-1:OFFS_W], addr_in[OFFS_W-1:0] ^ flip};
    end
endmodule

// File: rtl/lal_shift_plan.sv
// Lane shift planner.
// From the physical offset, length code and memory byte order it finds the boundary-crossing
// error and the lane shift in bytes. Full-width and crossing accesses get shift 0.
// Purely combinational.
module lal_shift_plan #(
    parameter int OFFS_W = 3
) (
    input  logic [OFFS_W-1:0] offs,
    input  logic [OFFS_W-1:0] len_code,
    input  logic              big_mem,
    output logic              cross_err,
    output logic              full_width,
    output logic [OFFS_W-1:0] shift_bytes
);
    localparam logic [OFFS_W-1:0] OFFS_MASK = '1;

    logic [OFFS_W:0] reach;

    // The end position carries out exactly when the access passes the element end.
    always_comb begin
        reach      = {1'b0, offs} + {1'b0, len_code};
        cross_err  = reach[OFFS_W];
        full_width = (len_code == OFFS_MASK);
    end

    // Choose the byte-order dependent shift, or none for full or illegal accesses.
    always_comb begin
        if (full_width || cross_err)
            shift_bytes = '0;
        else if (big_mem)
            shift_bytes = (OFFS_MASK - offs) - len_code;
        else
            shift_bytes = offs;
    end
endmodule

// File: rtl/lal_lane_mover.sv
// Lane mover.
// Masks the register-side bytes to the access length and shifts them in the direction
// the operation needs. For fetches it also applies the processor-order byte selection.
// Purely combinational.
module lal_lane_mover
    import lal_pkg::*;
#(
    parameter int ELEM_BYTES = 8,
    parameter int OFFS_W     = $clog2(ELEM_BYTES)
) (
    input  lal_op_e                  op,
    input  logic [ELEM_BYTES*8-1:0]  data_in,
    input  logic [OFFS_W-1:0]        len_code,
    input  logic [OFFS_W-1:0]        shift_bytes,
    input  logic [OFFS_W-1:0]        pick_bytes,
    output logic [ELEM_BYTES*8-1:0]  data_out
);
    localparam int DATA_W = ELEM_BYTES * 8;

    logic [DATA_W-1:0] len_keep;
    logic [DATA_W-1:0] placed;
    logic [DATA_W-1:0] lifted;
    logic [DATA_W-1:0] picked;

    // One byte of the keep mask per lane: lanes up to the length code stay.
    for (genvar g = 0; g < ELEM_BYTES; g++) begin : g_keep
        localparam logic [OFFS_W-1:0] LANE = OFFS_W'(g);
        assign len_keep[g*8 +: 8] = (LANE <= len_code) ? 8'hFF : 8'h00;
    end

    // Register side to memory side: trim, then move up.
    always_comb begin
        placed = (data_in & len_keep) << {shift_bytes, 3'b000};
    end

    // Memory side to register side: move down, then trim.
    always_comb begin
        lifted = (data_in >> {shift_bytes, 3'b000}) & len_keep;
    end

    // Fetch byte selection after the load placement.
    always_comb begin
        picked = placed >> {pick_bytes, 3'b000};
    end

    // Select by operation.
    always_comb begin
        unique case (op)
            LAL_STORE: data_out = lifted;
            LAL_FETCH: data_out = picked;
            default:   data_out = placed;
        endcase
    end
endmodule

// File: rtl/lal_byte_enable.sv
// Byte-enable generator.
// Sets a contiguous run of len_code+1 lanes starting at lane shift_bytes.
// Assumes the caller has already excluded crossing accesses. Purely combinational.
module lal_byte_enable #(
    parameter int ELEM_BYTES = 8,
    parameter int OFFS_W     = $clog2(ELEM_BYTES)
) (
    input  logic [OFFS_W-1:0]     len_code,
    input  logic [OFFS_W-1:0]     shift_bytes,
    output logic [ELEM_BYTES-1:0] lane_en
);
    logic [OFFS_W:0] first_lane;
    logic [OFFS_W:0] last_lane;

    // Bounds of the enabled run, widened so the sum cannot wrap.
    always_comb begin
        first_lane = {1'b0, shift_bytes};
        last_lane  = {1'b0, shift_bytes} + {1'b0, len_code};
    end

    // One comparator pair per lane.
    for (genvar g = 0; g < ELEM_BYTES; g++) begin : g_lane
        localparam logic [OFFS_W:0] LANE = (OFFS_W+1)'(g);
        assign lane_en[g] = (LANE >= first_lane) && (LANE <= last_lane);
    end
endmodule

// File: rtl/mem_lane_align.sv
// Endian-aware load/store lane aligner (top).
// Swizzles the address, plans the lane shift, moves the data and builds the store
// byte enables, then registers everything once. Crossing errors and fetch faults
// zero the data and the enables.
// Assumes ELEM_BYTES is a power of two and ADDR_W > log2(ELEM_BYTES).
module mem_lane_align
    import lal_pkg::*;
#(
    parameter int ELEM_BYTES = 8,
    parameter int ADDR_W     = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [1:0]               req_op,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [$clog2(ELEM_BYTES)-1:0] req_len,
    input  logic [ELEM_BYTES*8-1:0]  req_data,
    input  logic                     mem_big_endian,
    input  logic                     reverse_endian,
    input  logic                     cpu_big_endian,
    output logic                     rsp_valid,
    output logic [ADDR_W-1:0]        rsp_addr,
    output logic [ELEM_BYTES*8-1:0]  rsp_data,
    output logic [ELEM_BYTES-1:0]    rsp_be,
    output logic                     rsp_cross_err,
    output logic                     rsp_fetch_fault
);
    localparam int OFFS_W = $clog2(ELEM_BYTES);
    localparam int DATA_W = ELEM_BYTES * 8;
    localparam logic [OFFS_W-1:0] OFFS_MASK = '1;

    lal_op_e            op;
    logic [ADDR_W-1:0]  phys_addr;
    logic               cross_err;
    logic               full_width;
    logic [OFFS_W-1:0]  shift_bytes;
    logic [OFFS_W-1:0]  pick_bytes;
    logic [DATA_W-1:0]  moved;
    logic [ELEM_BYTES-1:0] lane_en;
    logic               fetch_fault;
    logic               kill;

    // Decode the raw operation field.
    always_comb begin
        op = lal_op_e'(req_op);
    end

    lal_addr_swizzle #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) u_swz (
        .addr_in  (req_addr),
        .len_code (req_len),
        .swz_en   (reverse_endian),
        .addr_out (phys_addr)
    );

    lal_shift_plan #(.OFFS_W(OFFS_W)) u_plan (
        .offs        (phys_addr[OFFS_W-1:0]),
        .len_code    (req_len),
        .big_mem     (mem_big_endian),
        .cross_err   (cross_err),
        .full_width  (full_width),
        .shift_bytes (shift_bytes)
    );

    // Fetch alignment check and processor-order byte pick, both on the unswizzled address.
    always_comb begin
        fetch_fault = (op == LAL_FETCH) && ((req_addr[OFFS_W-1:0] & req_len) != '0);
        pick_bytes  = req_addr[OFFS_W-1:0] ^ (cpu_big_endian ? (OFFS_MASK ^ req_len) : '0);
        kill        = cross_err || fetch_fault;
    end

    lal_lane_mover #(.ELEM_BYTES(ELEM_BYTES), .OFFS_W(OFFS_W)) u_move (
        .op          (op),
        .data_in     (req_data),
        .len_code    (req_len),
        .shift_bytes (shift_bytes),
        .pick_bytes  (pick_bytes),
        .data_out    (moved)
    );

    lal_byte_enable #(.ELEM_BYTES(ELEM_BYTES), .OFFS_W(OFFS_W)) u_be (
        .len_code    (req_len),
        .shift_bytes (shift_bytes),
        .lane_en     (lane_en)
    );

    // Strobe stage: valid follows the request by one clock.
    always_ff @(posedge clk) begin
        if (!rst_n) rsp_valid <= 1'b0;
        else        rsp_valid <= req_valid;
    end

    // Result stage: capture on a request, suppress data and enables on a fault.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_addr        <= '0;
            rsp_data        <= '0;
            rsp_be          <= '0;
            rsp_cross_err   <= 1'b0;
            rsp_fetch_fault <= 1'b0;
        end else if (req_valid) begin
            rsp_addr        <= phys_addr;
            rsp_data        <= kill ? '0 : moved;
            rsp_be          <= (kill || op != LAL_STORE) ? '0 : lane_en;
            rsp_cross_err   <= cross_err;
            rsp_fetch_fault <= fetch_fault;
        end
    end

    // R10: the strobe tracks the request one cycle later.
    p_valid_lag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    p_valid_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R1: a crossing access produces no data and no enables.
    p_cross_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_cross_err) |-> (rsp_be == '0 && rsp_data == '0));

    // R6: upper address bits are never touched.
    p_upper_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_addr[ADDR_W-1:OFFS_W] == $past(req_addr[ADDR_W-1:OFFS_W]));

    // R9: a clean store enables exactly len+1 lanes.
    p_be_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'd1) |=>
            (rsp_cross_err || $countones(rsp_be) == int'($past(req_len)) + 1));

    // R9: loads and fetches drive no enables.
    p_be_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op != 2'd1) |=> (rsp_be == '0));

    // R5: an aligned full-width load passes the element through untouched.
    p_full_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'd0 && req_len == OFFS_MASK && req_addr[OFFS_W-1:0] == '0)
            |=> (rsp_data == $past(req_data)));
endmodule

// File: tb/mem_lane_align_test.sv
`timescale 1ns/1ps
module mem_lane_align_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic [31:0] req_addr = '0;
    logic [2:0]  req_len = '0;
    logic [63:0] req_data = '0;
    logic        mem_big_endian = 1'b0;
    logic        reverse_endian = 1'b0;
    logic        cpu_big_endian = 1'b0;
    logic        rsp_valid;
    logic [31:0] rsp_addr;
    logic [63:0] rsp_data;
    logic [7:0]  rsp_be;
    logic        rsp_cross_err;
    logic        rsp_fetch_fault;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    mem_lane_align uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_len(req_len), .req_data(req_data),
        .mem_big_endian(mem_big_endian), .reverse_endian(reverse_endian),
        .cpu_big_endian(cpu_big_endian), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
        .rsp_data(rsp_data), .rsp_be(rsp_be), .rsp_cross_err(rsp_cross_err),
        .rsp_fetch_fault(rsp_fetch_fault)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h (op=%0d len=%0d addr=%h big=%0b rev=%0b cpu=%0b)",
                     req, act, exp, req_op, req_len, req_addr, mem_big_endian,
                     reverse_endian, cpu_big_endian);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int n = 0;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 reset valid", {63'd0, rsp_valid}, 64'd0);
        chk("R10 reset data", rsp_data, 64'd0);
        chk("R10 reset be", {56'd0, rsp_be}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 idle valid", {63'd0, rsp_valid}, 64'd0);

        for (int op = 0; op < 4; op++)
        for (int big = 0; big < 2; big++)
        for (int rev = 0; rev < 2; rev++)
        for (int cpu = 0; cpu < 2; cpu++)
        for (int len = 0; len < 8; len++)
        for (int off = 0; off < 8; off++) begin
            int pofs, sh, pick;
            bit err, flt, kill;
            logic [63:0] d, keep, e_data, placed;
            logic [7:0] e_be;
            logic [31:0] a;
            if (cpu == 1 && op != 2) continue;
            n++;
            a = (32'h9E37_0000 + 32'(n) * 32'h0001_0100) & 32'hFFFF_FFF8 | 32'(off);
            d = 64'h8877_6655_4433_2211 ^ ({32'(n), 32'(n)} * 64'h0000_0101_0001_0011);
            // expected values from the requirements
            pofs = rev ? (off ^ (7 ^ len)) : off;
            err  = (pofs + len) > 7;
            flt  = (op == 2) && ((off & len) != 0);
            kill = err || flt;
            sh   = (len == 7 || err) ? 0 : (big ? (7 - pofs - len) : pofs);
            keep = (len == 7) ? '1 : ((64'd1 << (8 * (len + 1))) - 64'd1);
            placed = (d & keep) << (8 * sh);
            pick = off ^ (cpu ? (7 ^ len) : 0);
            if (op == 1)      e_data = (d >> (8 * sh)) & keep;
            else if (op == 2) e_data = placed >> (8 * pick);
            else              e_data = placed;
            e_be = (op == 1) ? 8'(((16'd1 << (len + 1)) - 16'd1) << sh) : 8'd0;
            if (kill) begin
                e_data = '0;
                e_be = '0;
            end

            req_valid = 1'b1;
            req_op = 2'(op);
            req_addr = a;
            req_len = 3'(len);
            req_data = d;
            mem_big_endian = big[0];
            reverse_endian = rev[0];
            cpu_big_endian = cpu[0];
            @(negedge clk);
            chk("R10 valid", {63'd0, rsp_valid}, 64'd1);
            chk("R6 addr", {32'd0, rsp_addr}, {32'd0, a[31:3], 3'(pofs)});
            chk("R1 cross", {63'd0, rsp_cross_err}, {63'd0, err});
            chk("R7 fault", {63'd0, rsp_fetch_fault}, {63'd0, flt});
            chk("R9 be", {56'd0, rsp_be}, {56'd0, e_be});
            if (kill)          chk(flt ? "R7 data" : "R1 data", rsp_data, e_data);
            else if (len == 7) chk("R5 data", rsp_data, e_data);
            else if (op == 1)  chk("R4 data", rsp_data, e_data);
            else if (op == 2)  chk("R8 data", rsp_data, e_data);
            else if (big)      chk("R3 data", rsp_data, e_data);
            else               chk("R2 data", rsp_data, e_data);

            // R10: an idle cycle now and then drops the strobe
            if ((n % 97) == 0) begin
                req_valid = 1'b0;
                @(negedge clk);
                chk("R10 drop", {63'd0, rsp_valid}, 64'd0);
            end
        end
        req_valid = 1'b0;
        @(negedge clk);
        finish_run();
    end
endmodule